// File: doc/BRIEF.md
# Word-Serial Modular Subtraction Sequencer

This block computes (a − b) mod n for multi-word operands. Both a and b must already lie in the range 0 to n−1. The words are 16 bits wide and stream in least significant word first. The word count is set per operation.

The work is split into three micro-operations, and each one is a separate sweep over the word addresses. A single pass cannot produce both candidate results, because the adder/subtractor is modelled as a fully pipelined two-stage unit and its carry between words comes back from a register. The three steps are:

- The "difference" step stores a − b in an internal scratch bank. It also latches the final borrow.
- The "wrap" step stores a − b + n in a second scratch bank.
- The "pick" step copies one of the two scratch banks to the result write port. The latched borrow decides which one.

A controller issues the three steps in order. It reads operands through a synchronous read port, which returns data one cycle after the address. Results leave through a write-enable, address and data port.

Top module: `msub_sequencer`

## Requirements
- R1: With op code 0 (difference), the block reads operand word k at address k for k = 0..N−1 and stores word k of (a − b) mod 2^(16N) in the difference scratch bank. It latches the final borrow, which is 1 exactly when a < b. No result write occurs during this step.
- R2: With op code 1 (wrap), the block stores word k of (a − b + n) mod 2^(16N) in the wrap scratch bank. The per-word carry may be −1, 0 or +1. The latched borrow keeps its value, and no result write occurs.
- R3: With op code 2 (pick), the block asserts no operand read. It writes words 0..N−1 on the result port in ascending address order, one per cycle. Each word comes from the wrap bank when the latched borrow is 1 and from the difference bank when it is 0.
- R4: An active-low reset clears the latched borrow and both scratch banks. After that, only a difference step can change the borrow. A pick step issued before any difference step therefore writes the (zero) difference bank.
- R5: Suppose start is accepted at the clock edge that ends cycle c. Then the read address is k in cycle c+1+k, and result word k appears in cycle c+4+k. Done is a one-cycle pulse in cycle c+3+N, and the latched borrow is already updated in that cycle.
- R6: A start is ignored in three cases: op code 3, a word count of 0, or a word count above MAX_WORDS. An ignored start produces no read, no write and no done.
- R7: A start that arrives after acceptance and before the done cycle of the running operation is ignored.
- R8: While reset is low, rd_en, res_we and done are low.
- R9: The carry into word 0 is zero. The carry into every later word is the registered carry-out of the word before it, so a borrow or carry ripples across all N words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin the micro-operation on `op` |
| op | input | 2 | 0 difference, 1 wrap, 2 pick, 3 reserved |
| nwords | input | CNT_W (5) | Word count N, valid range 1..MAX_WORDS |
| rd_en | output | 1 | Operand read strobe |
| rd_addr | output | ADDR_W (4) | Operand word address |
| a_word | input | WORD_W (16) | Operand a word, valid the cycle after its address |
| b_word | input | WORD_W (16) | Operand b word, same timing |
| n_word | input | WORD_W (16) | Modulus word, same timing |
| res_we | output | 1 | Result write enable |
| res_addr | output | ADDR_W (4) | Result word address |
| res_data | output | WORD_W (16) | Result word |
| done | output | 1 | One-cycle pulse when the last word leaves the pipeline |

## Verification
The bench notes the cycle c in which it presents start, and it records the cycle number of every read, write and done pulse on the falling clock edge. A read of word k is due in c+1+k. Two registers later the operand reaches the adder, and one more register puts the result on the port, so the result write of word k is due in c+4+k. Done is due in c+3+N, together with the last write. Every check compares a recorded cycle number against these formulas, never against a count of elapsed waiting. Ignored starts are checked by the absence of any read, write or done within a window longer than a full sweep.

// File: rtl/msub_pkg.sv
package msub_pkg;

  typedef enum logic [1:0] {
    OP_DIFF = 2'd0,
    OP_WRAP = 2'd1,
    OP_PICK = 2'd2,
    OP_RSVD = 2'd3
  } msub_op_e;

  function automatic logic op_is_legal(input logic [1:0] code);
    return code != OP_RSVD;
  endfunction

  function automatic logic op_reads_operands(input msub_op_e kind);
    return (kind == OP_DIFF) || (kind == OP_WRAP);
  endfunction

endpackage

// File: rtl/msub_sweep.sv
module msub_sweep
  import msub_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_sel,
  input  logic [CNT_W-1:0]  nwords,
  input  logic              pipe_busy,
  output logic              accept,
  output logic              busy,
  output logic              iss_valid,
  output logic [ADDR_W-1:0] iss_idx,
  output logic              iss_first,
  output logic              iss_last,
  output msub_op_e          iss_op,
  output logic              rd_en
);

  logic              run_q;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] lim_q;
  msub_op_e          op_q;
  logic              len_ok;

  assign len_ok = (nwords != '0) && (nwords <= CNT_W'(MAX_WORDS));
  assign busy   = run_q || pipe_busy;
  assign accept = start && !busy && op_is_legal(op_sel) && len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
      op_q  <= OP_DIFF;
    end else if (accept) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      lim_q <= ADDR_W'(nwords - 1'b1);
      op_q  <= msub_op_e'(op_sel);
    end else if (run_q) begin
      if (cnt_q == lim_q) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign iss_valid = run_q;
  assign iss_idx   = cnt_q;
  assign iss_first = (cnt_q == '0);
  assign iss_last  = (cnt_q == lim_q);
  assign iss_op    = op_q;
  assign rd_en     = run_q && op_reads_operands(op_q);

endmodule

// File: rtl/msub_scratch.sv
module msub_scratch #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 16,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_diff,
  input  logic              wr_wrap,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_diff,
  output logic [WORD_W-1:0] rd_wrap
);

  localparam int NBANKS = 2;

  logic [NBANKS-1:0]             wr_vec;
  logic [NBANKS-1:0][WORD_W-1:0] rd_vec;

  assign wr_vec = {wr_wrap, wr_diff};

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic [WORD_W-1:0] mem_q [MAX_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < MAX_WORDS; i++) mem_q[i] <= '0;
      end else if (wr_vec[g]) begin
        mem_q[wr_idx] <= wr_word;
      end
    end

    assign rd_vec[g] = mem_q[rd_idx];
  end

  assign rd_diff = rd_vec[0];
  assign rd_wrap = rd_vec[1];

endmodule

// File: rtl/msub_pipe.sv
module msub_pipe
  import msub_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [ADDR_W-1:0] iss_idx,
  input  logic              iss_first,
  input  logic              iss_last,
  input  msub_op_e          iss_op,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  logic [WORD_W-1:0] n_word,
  input  logic [WORD_W-1:0] sd_word,
  input  logic [WORD_W-1:0] sw_word,
  output logic [ADDR_W-1:0] s0_idx,
  output logic              s2_valid,
  output logic [ADDR_W-1:0] s2_idx,
  output logic              s2_last,
  output msub_op_e          s2_op,
  output logic [WORD_W-1:0] s2_word,
  output logic              borrow_q,
  output logic              borrow_upd,
  output logic              pipe_busy
);

  // One word step: result in the low WORD_W bits, signed carry (-1, 0, +1)
  // in the top two bits. The pick step passes x through unchanged.
  function automatic logic [WORD_W+1:0] word_step(
    input msub_op_e          kind,
    input logic [WORD_W-1:0] x,
    input logic [WORD_W-1:0] y,
    input logic [WORD_W-1:0] m,
    input logic [1:0]        cin
  );
    logic [WORD_W+1:0] add_m;
    logic [WORD_W+1:0] acc;
    add_m = (kind == OP_WRAP) ? {2'b00, m} : '0;
    acc   = {2'b00, x} - {2'b00, y} + add_m + {{WORD_W{cin[1]}}, cin};
    if (kind == OP_PICK) return {2'b00, x};
    return acc;
  endfunction

  // stage 0: address phase registered, operand data arrives this cycle
  logic        s0_valid, s0_first, s0_last;
  msub_op_e    s0_op;
  // stage 1: operands registered
  logic              s1_valid, s1_first, s1_last;
  logic [ADDR_W-1:0] s1_idx;
  msub_op_e          s1_op;
  logic [WORD_W-1:0] s1_x, s1_y, s1_m;
  // carry chain
  logic [1:0]        carry_q;
  logic [1:0]        cin;
  logic [WORD_W+1:0] step;
  logic [WORD_W-1:0] opx, opy, opm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_valid <= 1'b0;
      s0_idx   <= '0;
      s0_first <= 1'b0;
      s0_last  <= 1'b0;
      s0_op    <= OP_DIFF;
    end else begin
      s0_valid <= iss_valid;
      s0_idx   <= iss_idx;
      s0_first <= iss_first;
      s0_last  <= iss_last;
      s0_op    <= iss_op;
    end
  end

  always_comb begin
    if (s0_op == OP_PICK) begin
      opx = borrow_q ? sw_word : sd_word;
      opy = '0;
      opm = '0;
    end else begin
      opx = a_word;
      opy = b_word;
      opm = n_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_op    <= OP_DIFF;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_m     <= '0;
    end else begin
      s1_valid <= s0_valid;
      s1_idx   <= s0_idx;
      s1_first <= s0_first;
      s1_last  <= s0_last;
      s1_op    <= s0_op;
      s1_x     <= opx;
      s1_y     <= opy;
      s1_m     <= opm;
    end
  end

  assign cin        = s1_first ? 2'b00 : carry_q;
  assign step       = word_step(s1_op, s1_x, s1_y, s1_m, cin);
  assign borrow_upd = s1_valid && s1_last && (s1_op == OP_DIFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q  <= 2'b00;
      borrow_q <= 1'b0;
      s2_valid <= 1'b0;
      s2_idx   <= '0;
      s2_last  <= 1'b0;
      s2_op    <= OP_DIFF;
      s2_word  <= '0;
    end else begin
      if (s1_valid) carry_q <= step[WORD_W+1:WORD_W];
      if (borrow_upd) borrow_q <= step[WORD_W+1];
      s2_valid <= s1_valid;
      s2_idx   <= s1_idx;
      s2_last  <= s1_last;
      s2_op    <= s1_op;
      s2_word  <= step[WORD_W-1:0];
    end
  end

  assign pipe_busy = s0_valid || s1_valid || (s2_valid && !s2_last);

endmodule

// File: rtl/msub_sequencer.sv
module msub_sequencer
  import msub_pkg::*;
#(
  parameter  int WORD_W    = 16,
  parameter  int MAX_WORDS = 16,
  localparam int ADDR_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [CNT_W-1:0]  nwords,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  logic [WORD_W-1:0] n_word,
  output logic              res_we,
  output logic [ADDR_W-1:0] res_addr,
  output logic [WORD_W-1:0] res_data,
  output logic              done
);

  logic              accept, busy, pipe_busy;
  logic              iss_valid, iss_first, iss_last;
  logic [ADDR_W-1:0] iss_idx;
  msub_op_e          iss_op;
  logic [ADDR_W-1:0] s0_idx;
  logic              s2_valid, s2_last;
  logic [ADDR_W-1:0] s2_idx;
  msub_op_e          s2_op;
  logic [WORD_W-1:0] s2_word;
  logic              borrow_q, borrow_upd;
  logic [WORD_W-1:0] sd_word, sw_word;
  logic              wr_diff, wr_wrap;

  msub_sweep #(
    .MAX_WORDS(MAX_WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_sel    (op),
    .nwords    (nwords),
    .pipe_busy (pipe_busy),
    .accept    (accept),
    .busy      (busy),
    .iss_valid (iss_valid),
    .iss_idx   (iss_idx),
    .iss_first (iss_first),
    .iss_last  (iss_last),
    .iss_op    (iss_op),
    .rd_en     (rd_en)
  );

  assign rd_addr = iss_idx;

  msub_pipe #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_idx    (iss_idx),
    .iss_first  (iss_first),
    .iss_last   (iss_last),
    .iss_op     (iss_op),
    .a_word     (a_word),
    .b_word     (b_word),
    .n_word     (n_word),
    .sd_word    (sd_word),
    .sw_word    (sw_word),
    .s0_idx     (s0_idx),
    .s2_valid   (s2_valid),
    .s2_idx     (s2_idx),
    .s2_last    (s2_last),
    .s2_op      (s2_op),
    .s2_word    (s2_word),
    .borrow_q   (borrow_q),
    .borrow_upd (borrow_upd),
    .pipe_busy  (pipe_busy)
  );

  assign wr_diff = s2_valid && (s2_op == OP_DIFF);
  assign wr_wrap = s2_valid && (s2_op == OP_WRAP);

  msub_scratch #(
    .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .ADDR_W(ADDR_W)
  ) u_scratch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_diff (wr_diff),
    .wr_wrap (wr_wrap),
    .wr_idx  (s2_idx),
    .wr_word (s2_word),
    .rd_idx  (s0_idx),
    .rd_diff (sd_word),
    .rd_wrap (sw_word)
  );

  assign res_we   = s2_valid && (s2_op == OP_PICK);
  assign res_addr = s2_idx;
  assign res_data = s2_word;
  assign done     = s2_valid && s2_last;

endmodule

// File: rtl/msub_checker.sv
module msub_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              res_we,
  input logic [ADDR_W-1:0] res_addr,
  input logic              done,
  input logic              busy,
  input logic              accept,
  input logic              borrow_q,
  input logic              borrow_upd
);

  // R3: the pick step reads no operands, the other steps write no result
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && res_we));

  // R3: result words leave in ascending address order, one per cycle
  p_write_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && $past(res_we)) |-> (res_addr == ADDR_W'($past(res_addr) + 1'b1)));

  // R4: the latched borrow moves only on a difference-step latch event
  p_borrow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(borrow_q) |-> $past(borrow_upd));

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: an operand sweep begins at address zero right after acceptance
  p_read_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> ($past(accept) && rd_addr == '0));

  // R7: an accepted operation holds the block busy in the next cycle
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

endmodule

bind msub_sequencer msub_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .res_we     (res_we),
  .res_addr   (res_addr),
  .done       (done),
  .busy       (busy),
  .accept     (accept),
  .borrow_q   (borrow_q),
  .borrow_upd (borrow_upd)
);

// File: tb/msub_sequencer_tb.sv
module msub_sequencer_tb;

  localparam int WW = 16;
  localparam int MW = 16;
  localparam int AW = 4;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [CW-1:0] nwords = '0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] a_word = '0, b_word = '0, n_word = '0;
  logic          res_we;
  logic [AW-1:0] res_addr;
  logic [WW-1:0] res_data;
  logic          done;

  always #5 clk = ~clk;

  msub_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .nwords(nwords),
    .rd_en(rd_en), .rd_addr(rd_addr), .a_word(a_word), .b_word(b_word),
    .n_word(n_word), .res_we(res_we), .res_addr(res_addr),
    .res_data(res_data), .done(done)
  );

  // operand banks, synchronous read
  logic [WW-1:0] mem_a [MW], mem_b [MW], mem_n [MW];
  always @(posedge clk) if (rd_en) begin
    a_word <= mem_a[rd_addr];
    b_word <= mem_b[rd_addr];
    n_word <= mem_n[rd_addr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // observation
  logic [WW-1:0] got [MW];
  int wr_cyc [MW];
  int n_wr, n_rd, n_done, rd_first, done_cyc;
  bit rd_order_bad, wr_order_bad;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_we) begin
        if (int'(res_addr) != n_wr) wr_order_bad = 1'b1;
        got[res_addr] = res_data;
        wr_cyc[res_addr] = cyc;
        n_wr++;
      end
      if (rd_en) begin
        if (n_rd == 0) rd_first = cyc;
        if (int'(rd_addr) != n_rd) rd_order_bad = 1'b1;
        n_rd++;
      end
      if (done) begin
        n_done++;
        done_cyc = cyc;
      end
    end
  end

  // model of the scratch banks and the latched borrow
  logic [WW-1:0] mdl_d [MW], mdl_w [MW];
  bit mdl_borrow;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    n_wr = 0; n_rd = 0; n_done = 0; rd_first = -1; done_cyc = -1;
    rd_order_bad = 1'b0; wr_order_bad = 1'b0;
    for (int k = 0; k < MW; k++) begin got[k] = '0; wr_cyc[k] = -1; end
  endtask

  task automatic load(input int k, input logic [WW-1:0] av, bv, nv);
    mem_a[k] = av; mem_b[k] = bv; mem_n[k] = nv;
  endtask

  // bench's own big-number view of the operand banks
  task automatic model_step(input int o, input int n);
    logic [MW*WW-1:0] av, bv, nv, r;
    av = '0; bv = '0; nv = '0;
    for (int k = 0; k < n; k++) begin
      av[k*WW +: WW] = mem_a[k];
      bv[k*WW +: WW] = mem_b[k];
      nv[k*WW +: WW] = mem_n[k];
    end
    if (o == 0) begin
      r = av - bv;
      mdl_borrow = (av < bv);
      for (int k = 0; k < n; k++) mdl_d[k] = r[k*WW +: WW];
    end else if (o == 1) begin
      r = av - bv + nv;
      for (int k = 0; k < n; k++) mdl_w[k] = r[k*WW +: WW];
    end
  endtask

  task automatic run_op(input int o, input int n, input string req);
    int c;
    bit legal;
    legal = (o != 3) && (n >= 1) && (n <= MW);
    clear_obs();
    @(negedge clk);
    op = 2'(o); nwords = CW'(n); start = 1'b1; c = cyc;
    @(negedge clk);
    start = 1'b0;
    repeat (n + 10) @(negedge clk);
    #1;
    if (!legal) begin
      chk(n_done == 0, {req, " R6 no done"}, n_done, 0);
      chk(n_rd == 0, {req, " R6 no read"}, n_rd, 0);
      chk(n_wr == 0, {req, " R6 no write"}, n_wr, 0);
      return;
    end
    chk(n_done == 1, {req, " R5 one done"}, n_done, 1);
    chk(done_cyc == c + 3 + n, {req, " R5 done cycle"}, done_cyc - c, 3 + n);
    if (o != 2) begin
      chk(n_rd == n, {req, " R1 read count"}, n_rd, n);
      chk(rd_first == c + 1, {req, " R5 first read cycle"}, rd_first - c, 1);
      chk(!rd_order_bad, {req, " R1 read order"}, rd_order_bad, 0);
      chk(n_wr == 0, {req, " R3 no write in X/Y"}, n_wr, 0);
      model_step(o, n);
    end else begin
      chk(n_rd == 0, {req, " R3 no read in pick"}, n_rd, 0);
      chk(n_wr == n, {req, " R3 write count"}, n_wr, n);
      chk(!wr_order_bad, {req, " R3 write order"}, wr_order_bad, 0);
      for (int k = 0; k < n; k++) begin
        logic [WW-1:0] e;
        e = mdl_borrow ? mdl_w[k] : mdl_d[k];
        chk(got[k] == e, {req, " R3 word"}, got[k], e);
        chk(wr_cyc[k] == c + 4 + k, {req, " R5 write cycle"}, wr_cyc[k] - c, 4 + k);
      end
    end
  endtask

  // scenarios
  task automatic t_reset();
    chk(!rd_en && !res_we && !done, "R8 outputs in reset", {rd_en, res_we, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_en && !res_we && !done, "R8 outputs after reset", {rd_en, res_we, done}, 0);
  endtask

  task automatic t_pick_first();
    for (int k = 0; k < 4; k++) load(k, 16'h1000 + 16'(k), 16'h0800, 16'h2000);
    run_op(1, 4, "R2 wrap after reset");
    run_op(2, 4, "R4 pick before diff uses zero borrow");
  endtask

  task automatic t_no_borrow();
    load(0, 16'h1234, 16'h2345, 16'hFFFF);
    load(1, 16'h0000, 16'h0001, 16'hFFFF);
    load(2, 16'hABCD, 16'h0BCD, 16'hFFFF);
    load(3, 16'h4000, 16'h1000, 16'h7FFF);
    run_op(0, 4, "R1 diff no final borrow");
    run_op(2, 4, "R9 pick diff with inner borrows");
  endtask

  task automatic t_borrow_chain();
    // a = 0xFFFF, b = 0x1_0000, n = 0x8000_0000_0000_0002: both carry signs
    load(0, 16'hFFFF, 16'h0000, 16'h0002);
    load(1, 16'h0000, 16'h0001, 16'h0000);
    load(2, 16'h0000, 16'h0000, 16'h0000);
    load(3, 16'h0000, 16'h0000, 16'h8000);
    run_op(0, 4, "R1 diff with final borrow");
    run_op(1, 4, "R9 wrap with positive carry");
    run_op(2, 4, "R3 pick wrap bank");
  endtask

  task automatic t_wrap_keeps_borrow();
    for (int k = 0; k < 4; k++) load(k, 16'h9000 - 16'(k), 16'h0100, 16'hA000);
    run_op(1, 4, "R2 wrap leaves borrow set");
    run_op(2, 4, "R2 pick after wrap still wrap bank");
    run_op(0, 4, "R4 diff clears borrow");
    run_op(2, 4, "R4 pick diff bank");
  endtask

  task automatic t_sizes();
    load(0, 16'h0003, 16'h0007, 16'h0010);
    run_op(0, 1, "R1 single word diff");
    run_op(1, 1, "R2 single word wrap");
    run_op(2, 1, "R3 single word pick");
    for (int k = 0; k < MW; k++) load(k, 16'h0000, (k == 0) ? 16'h0001 : 16'h0000,
                                      (k == MW - 1) ? 16'h0100 : 16'h0000);
    run_op(0, MW, "R9 full-length borrow ripple");
    run_op(1, MW, "R9 full-length wrap");
    run_op(2, MW, "R3 full-length pick");
  endtask

  task automatic t_illegal();
    run_op(3, 4, "R6 reserved op");
    run_op(0, 0, "R6 zero length");
    run_op(0, MW + 1, "R6 overlong");
    run_op(2, MW, "R6 state kept after ignored starts");
  endtask

  task automatic t_busy();
    int c;
    for (int k = 0; k < 8; k++) load(k, 16'h5555, 16'h6666, 16'hFFFF);
    clear_obs();
    @(negedge clk);
    op = 2'd0; nwords = CW'(8); start = 1'b1; c = cyc;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    op = 2'd2; nwords = CW'(4); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk(n_done == 1, "R7 only one done", n_done, 1);
    chk(n_wr == 0, "R7 pick during sweep ignored", n_wr, 0);
    chk(done_cyc == c + 11, "R7 running op timing kept", done_cyc - c, 11);
    model_step(0, 8);
    run_op(2, 8, "R7 result of uninterrupted diff");
  endtask

  initial begin
    for (int k = 0; k < MW; k++) begin
      mdl_d[k] = '0; mdl_w[k] = '0; load(k, '0, '0, '0);
    end
    mdl_borrow = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_pick_first();
    t_no_borrow();
    t_borrow_chain();
    t_wrap_keeps_borrow();
    t_sizes();
    t_illegal();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog actual=%0d expected=completion", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule